// File: doc/BRIEF.md
# Stream FIFO with Threshold-Gated Burst Drain

This block is the staging buffer that sits between the memory-facing port and the peripheral-facing port of a single DMA stream. It holds 16 bytes. Items arrive on a fill port, one item per beat, in the source item size (8, 16 or 32 bits). Items leave on a drain port in the destination item size, which may differ. Because the buffer is kept as a byte ring, packing narrow items into wide ones and unpacking wide items into narrow ones both follow from the byte order. Neither needs a data path of its own.

In buffered mode the drain side waits until the byte level reaches a programmed fill threshold. Once the threshold is reached, the block becomes armed. It then keeps issuing drain bursts of a fixed beat count as long as a whole burst's worth of bytes is present, and it disarms only when less than one burst remains. On the fill side, a burst of several beats is admitted only when the whole burst fits in the free space. A burst on either side always runs to its last beat.

In pass-through mode the threshold and both burst lengths are ignored: every destination item goes out as a single beat as soon as its bytes are present. A synchronous flush empties the buffer, including any bytes of a partly packed item.

Top module: `sfifo_top`

## Requirements
- R1: Fill-side ready is high only when the free space (16 minus the level) is at least one source item. When no fill burst is in progress, the free space must also cover the whole fill burst. Size code 0/1/2 means 1/2/4 bytes, and burst code 0/1/2/3 means 1/4/8/16 beats. A fill burst, once its first beat is taken, is admitted to its last beat.
- R2: Threshold code 0/1/2/3 selects 4/8/12/16 bytes. In buffered mode, drain valid stays low while the block is not armed and the level is below the threshold. For example, a single byte at a 12-byte threshold never leaves.
- R3: Once the threshold is met, the block stays armed. It starts drain bursts whenever the level covers a whole drain burst, and it disarms when an idle drain side finds less than one burst.
- R4: A drain burst keeps valid high and its data stable until its last beat. out_last_o is high exactly on the final beat of each burst, and on every beat of a single-beat transfer.
- R5: Wide-to-narrow unpacking emits the bytes lowest first. The lane 0 byte (bits 7:0) of an accepted source word leaves first. Lanes above the destination item size read as zero.
- R6: Narrow-to-wide packing places the first byte received in lane 0 (bits 7:0), the next in lane 1, and so on.
- R7: With 32-bit source items, 8-bit destination items, a 16-byte threshold and 4-beat drain bursts, four accepted words produce 16 byte beats in four bursts of four.
- R8: In pass-through mode, drain valid rises in the cycle after the level covers one destination item, whatever the threshold. Each beat is marked last, and fill ready requires only one item of free space.
- R9: While flush_i is high, both ready and valid are low. In the next cycle the buffer is empty, so bytes received before the flush can never count toward a later threshold.
- R10: After reset the buffer is empty, drain valid is low and fill ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous clear of contents and burst state |
| passthru_i | input | 1 | 1: pass-through mode, 0: threshold-buffered mode |
| src_size_i | input | 2 | Fill item size code |
| src_burst_i | input | 2 | Fill burst length code |
| dst_size_i | input | 2 | Drain item size code |
| dst_burst_i | input | 2 | Drain burst length code |
| fill_thr_i | input | 2 | Fill threshold code |
| in_valid_i | input | 1 | Fill beat offered |
| in_ready_o | output | 1 | Fill beat can be taken |
| in_data_i | input | 32 | Fill data, item in the low lanes |
| out_valid_o | output | 1 | Drain beat offered |
| out_ready_i | input | 1 | Drain beat taken |
| out_data_o | output | 32 | Drain data, item in the low lanes |
| out_last_o | output | 1 | Final beat of the current drain burst |

## Verification
The hardest state to reach from the ports is an armed buffer whose level has fallen below the threshold but still covers a burst, while a fill burst is locked out by missing free space. That state decides whether draining continues or the stream stalls. The stimulus gets there in two ways. One is to hold the drain side off while a full fill burst lands and then release it for a counted number of cycles. The other is to run long random segments with legal but mismatched sizes and burst lengths, re-programmed through flush. A behavioural byte-queue model judges ready, valid, last and data on every cycle.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef logic [7:0] bcnt_t;

  function automatic bcnt_t size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd1;
      2'd1:    return 8'd2;
      default: return 8'd4;
    endcase
  endfunction

  function automatic bcnt_t burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd8;
      default: return 8'd16;
    endcase
  endfunction

  function automatic bcnt_t thr_bytes(input logic [1:0] code, input bcnt_t depth);
    return (depth >> 2) * ({6'd0, code} + 8'd1);
  endfunction
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               we_i,
  input  bcnt_t              wr_n_i,
  input  logic [LANES*8-1:0] wdata_i,
  input  logic               re_i,
  input  bcnt_t              rd_n_i,
  output logic [LANES*8-1:0] rdata_o,
  output logic [LVL_W-1:0]   level_o
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level;

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int i = 0; i < LANES; i++) begin
        if (bcnt_t'(i) < wr_n_i) mem[wr_ptr + PTR_W'(i)] <= wdata_i[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (we_i) wr_ptr <= wr_ptr + PTR_W'(wr_n_i);
      if (re_i) rd_ptr <= rd_ptr + PTR_W'(rd_n_i);
      level <= level + (we_i ? LVL_W'(wr_n_i) : '0) - (re_i ? LVL_W'(rd_n_i) : '0);
    end
  end

  // lanes above the drain item size read as zero
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      rdata_o[8*i +: 8] = (bcnt_t'(i) < rd_n_i) ? mem[rd_ptr + PTR_W'(i)] : 8'h00;
    end
  end

  assign level_o = level;
endmodule

// File: rtl/sfifo_fill_ctl.sv
module sfifo_fill_ctl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             passthru_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       burst_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             we_o,
  output bcnt_t            wr_n_o
);
  bcnt_t free, item, beats, need, left;
  logic  active;

  assign free   = bcnt_t'(DEPTH) - bcnt_t'(level_i);
  assign item   = size_bytes(size_i);
  assign beats  = passthru_i ? 8'd1 : burst_beats(burst_i);
  assign need   = item * beats;
  // whole burst must fit before its first beat is taken
  assign ready_o = !flush_i && (free >= item) && (active || free >= need);
  assign we_o    = valid_i && ready_o;
  assign wr_n_o  = item;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      left   <= '0;
    end else if (flush_i) begin
      active <= 1'b0;
      left   <= '0;
    end else if (we_o) begin
      if (active) begin
        left <= left - 8'd1;
        if (left == 8'd1) active <= 1'b0;
      end else if (beats > 8'd1) begin
        active <= 1'b1;
        left   <= beats - 8'd1;
      end
    end
  end
endmodule

// File: rtl/sfifo_drain_ctl.sv
module sfifo_drain_ctl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             passthru_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       burst_i,
  input  logic [1:0]       thr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             last_o,
  output logic             re_o,
  output bcnt_t            rd_n_o
);
  bcnt_t lvl, item, beats, need, thr, left;
  logic  active, armed, go;

  assign lvl   = bcnt_t'(level_i);
  assign item  = size_bytes(size_i);
  assign beats = passthru_i ? 8'd1 : burst_beats(burst_i);
  assign need  = item * beats;
  assign thr   = thr_bytes(thr_i, bcnt_t'(DEPTH));
  // armed keeps draining below the threshold until less than a burst remains
  assign go = !active && (passthru_i ? (lvl >= item)
                                     : ((armed || lvl >= thr) && lvl >= need));
  assign valid_o = !flush_i && (active || go);
  assign last_o  = active ? (left == 8'd1) : (beats == 8'd1);
  assign re_o    = valid_o && ready_i;
  assign rd_n_o  = item;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      armed  <= 1'b0;
      left   <= '0;
    end else if (flush_i) begin
      active <= 1'b0;
      armed  <= 1'b0;
      left   <= '0;
    end else begin
      if (!active) armed <= go;
      if (re_o) begin
        if (active) begin
          left <= left - 8'd1;
          if (left == 8'd1) active <= 1'b0;
        end else if (beats > 8'd1) begin
          active <= 1'b1;
          left   <= beats - 8'd1;
        end
      end
    end
  end
endmodule

// File: rtl/sfifo_top.sv
module sfifo_top
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              passthru_i,
  input  logic [1:0]        src_size_i,
  input  logic [1:0]        src_burst_i,
  input  logic [1:0]        dst_size_i,
  input  logic [1:0]        dst_burst_i,
  input  logic [1:0]        fill_thr_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o
);
  localparam int LANES = DATA_W / 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] level;
  logic             we, re;
  bcnt_t            wr_n, rd_n;

  sfifo_fill_ctl #(.DEPTH(DEPTH)) u_fill (
    .clk_i, .rst_ni, .flush_i, .passthru_i,
    .size_i (src_size_i),
    .burst_i(src_burst_i),
    .level_i(level),
    .valid_i(in_valid_i),
    .ready_o(in_ready_o),
    .we_o   (we),
    .wr_n_o (wr_n)
  );

  sfifo_drain_ctl #(.DEPTH(DEPTH)) u_drain (
    .clk_i, .rst_ni, .flush_i, .passthru_i,
    .size_i (dst_size_i),
    .burst_i(dst_burst_i),
    .thr_i  (fill_thr_i),
    .level_i(level),
    .ready_i(out_ready_i),
    .valid_o(out_valid_o),
    .last_o (out_last_o),
    .re_o   (re),
    .rd_n_o (rd_n)
  );

  sfifo_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk_i, .rst_ni, .flush_i,
    .we_i   (we),
    .wr_n_i (wr_n),
    .wdata_i(in_data_i),
    .re_i   (re),
    .rd_n_i (rd_n),
    .rdata_o(out_data_o),
    .level_o(level)
  );
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              passthru_i,
  input logic [1:0]        src_size_i,
  input logic [1:0]        dst_size_i,
  input logic [1:0]        dst_burst_i,
  input logic              in_valid_i,
  input logic              in_ready_i,
  input logic              out_valid_i,
  input logic              out_ready_i,
  input logic              out_last_i,
  input logic [DATA_W-1:0] out_data_i,
  input logic [LVL_W-1:0]  level_i
);
  bcnt_t lvl, need;
  assign lvl  = bcnt_t'(level_i);
  assign need = size_bytes(dst_size_i) * burst_beats(dst_burst_i);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_i) |-> (bcnt_t'(DEPTH) - lvl) >= size_bytes(src_size_i)); // R1
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl <= bcnt_t'(DEPTH)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && out_ready_i) |-> lvl >= size_bytes(dst_size_i)); // R3
  AST_START_HAS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_valid_i) && !passthru_i) |-> lvl >= need); // R3
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i && !flush_i) |=> (flush_i || (out_valid_i && $stable(out_data_i)))); // R4
  AST_BURST_GAPLESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && out_ready_i && !out_last_i && !flush_i) |=> (flush_i || out_valid_i)); // R4
  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!in_ready_i && !out_valid_i)); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> lvl == 8'd0); // R9
endmodule

bind sfifo_top sfifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .passthru_i  (passthru_i),
  .src_size_i  (src_size_i),
  .dst_size_i  (dst_size_i),
  .dst_burst_i (dst_burst_i),
  .in_valid_i  (in_valid_i),
  .in_ready_i  (in_ready_o),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_last_i  (out_last_o),
  .out_data_i  (out_data_o),
  .level_i     (level)
);

// File: tb/sfifo_top_tb_top.sv
`timescale 1ns/1ps
module sfifo_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, passthru = 1'b0;
  logic [1:0]  src_size = 2'd2, src_burst = 2'd0, dst_size = 2'd2, dst_burst = 2'd0, thr = 2'd0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_last;
  logic [31:0] out_data;

  always #10 clk = ~clk;

  sfifo_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .passthru_i(passthru),
    .src_size_i(src_size), .src_burst_i(src_burst), .dst_size_i(dst_size),
    .dst_burst_i(dst_burst), .fill_thr_i(thr),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference
  logic [7:0] q[$];
  bit m_fa = 0, m_da = 0, m_arm = 0;
  int m_fl = 0, m_dl = 0;
  bit last_in_hs;
  logic [7:0] nb = 8'h00;
  int beats_seen = 0, lasts_seen = 0;
  logic [7:0] seen[$];

  function automatic int sz(logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction
  function automatic int bt(logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 16;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    int lvl, mb, pb, mbt, pbt, th;
    bit e_ir, e_go, e_ov, e_last;
    logic [31:0] e_data;
    @(negedge clk); #1;
    lvl = q.size(); mb = sz(src_size); pb = sz(dst_size);
    mbt = passthru ? 1 : bt(src_burst); pbt = passthru ? 1 : bt(dst_burst);
    th = 4 * (int'(thr) + 1);
    e_ir = !flush && (16 - lvl) >= mb && (m_fa || (16 - lvl) >= mb * mbt);
    e_go = !m_da && (passthru ? (lvl >= pb) : ((m_arm || lvl >= th) && lvl >= pb * pbt));
    e_ov = !flush && (m_da || e_go);
    e_last = m_da ? (m_dl == 1) : (pbt == 1);
    e_data = '0;
    for (int i = 0; i < 4; i++) if (i < pb && i < lvl) e_data[8*i +: 8] = q[i];
    chk(in_ready == e_ir, "R1", "in_ready", 32'(in_ready), 32'(e_ir));
    chk(out_valid == e_ov, "R2", "out_valid", 32'(out_valid), 32'(e_ov));
    if (e_ov) begin
      chk(out_data == e_data, "R5", "out_data", out_data, e_data);
      chk(out_last == e_last, "R4", "out_last", 32'(out_last), 32'(e_last));
    end
    if (out_valid && out_ready) begin
      beats_seen++;
      if (out_last) lasts_seen++;
      for (int i = 0; i < pb; i++) seen.push_back(out_data[8*i +: 8]);
    end
    last_in_hs = e_ir && in_valid;
    @(posedge clk);
    if (flush) begin
      q.delete(); m_fa = 0; m_da = 0; m_arm = 0; m_fl = 0; m_dl = 0;
    end else begin
      if (last_in_hs) begin
        for (int i = 0; i < mb; i++) q.push_back(in_data[8*i +: 8]);
        if (m_fa) begin m_fl--; if (m_fl == 0) m_fa = 0; end
        else if (mbt > 1) begin m_fa = 1; m_fl = mbt - 1; end
      end
      if (!m_da) m_arm = e_go;
      if (e_ov && out_ready) begin
        for (int i = 0; i < pb; i++) void'(q.pop_front());
        if (m_da) begin m_dl--; if (m_dl == 0) m_da = 0; end
        else if (pbt > 1) begin m_da = 1; m_dl = pbt - 1; end
      end
    end
    #1;
  endtask

  task automatic feed(int n);
    int got = 0;
    while (got < n) begin
      in_valid = 1'b1;
      in_data  = {nb + 8'd3, nb + 8'd2, nb + 8'd1, nb};
      step();
      if (last_in_hs) begin got++; nb = nb + 8'(sz(src_size)); end
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) step();
  endtask

  task automatic set_cfg(bit d, logic [1:0] ms, logic [1:0] mbu, logic [1:0] ps,
                         logic [1:0] pbu, logic [1:0] th);
    passthru = d; src_size = ms; src_burst = mbu; dst_size = ps; dst_burst = pbu; thr = th;
    in_valid = 1'b0; flush = 1'b1;
    step();
    flush = 1'b0;
    beats_seen = 0; lasts_seen = 0; seen.delete();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R4 act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] base;
    bit ok;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(in_ready == 1'b1, "R10", "reset in_ready", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R10", "reset out_valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R7: word in, byte out, full threshold, 4-beat drain bursts
    set_cfg(0, 2'd2, 2'd1, 2'd0, 2'd1, 2'd3);
    out_ready = 1'b1; base = nb;
    feed(4); idle(30);
    chk(beats_seen == 16, "R7", "byte beats", 32'(beats_seen), 32'd16);
    chk(lasts_seen == 4, "R7", "bursts", 32'(lasts_seen), 32'd4);
    ok = (seen.size() == 16);
    for (int i = 0; i < seen.size(); i++) if (seen[i] != base + 8'(i)) ok = 0;
    chk(ok, "R5", "byte order", 32'(seen.size()), 32'd16);

    // R2 / R3: single byte at 12-byte threshold stays; reaching 12 drains all
    set_cfg(0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2);
    out_ready = 1'b1;
    feed(1); idle(20);
    chk(beats_seen == 0, "R2", "one byte held", 32'(beats_seen), 32'd0);
    feed(10); idle(5);
    chk(beats_seen == 0, "R2", "11 bytes held", 32'(beats_seen), 32'd0);
    feed(1); idle(20);
    chk(beats_seen == 12, "R3", "armed drain", 32'(beats_seen), 32'd12);

    // R8: pass-through ignores threshold and bursts
    set_cfg(1, 2'd0, 2'd3, 2'd0, 2'd3, 2'd3);
    out_ready = 1'b0;
    feed(1);
    @(negedge clk); #1;
    chk(out_valid == 1'b1, "R8", "pass-through valid", 32'(out_valid), 32'd1);
    chk(out_last == 1'b1, "R8", "pass-through last", 32'(out_last), 32'd1);
    @(posedge clk); #1;
    out_ready = 1'b1; idle(3);
    chk(beats_seen == 1, "R8", "pass-through beats", 32'(beats_seen), 32'd1);

    // R6: byte in, word out
    set_cfg(0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0);
    out_ready = 1'b0; base = nb;
    feed(4); idle(2);
    chk(out_valid == 1'b1, "R6", "packed valid", 32'(out_valid), 32'd1);
    chk(out_data == {base + 8'd3, base + 8'd2, base + 8'd1, base}, "R6", "packed word",
        out_data, {base + 8'd3, base + 8'd2, base + 8'd1, base});

    // R5: word in, half out, upper lanes zero
    set_cfg(0, 2'd2, 2'd0, 2'd1, 2'd0, 2'd0);
    out_ready = 1'b0; base = nb;
    feed(1); idle(2);
    chk(out_data == {16'h0, base + 8'd1, base}, "R5", "half unpack", out_data,
        {16'h0, base + 8'd1, base});

    // R9: flush drops partial bytes
    set_cfg(0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1);
    out_ready = 1'b1;
    feed(3);
    flush = 1'b1;
    @(negedge clk); #1;
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R9", "quiet in flush",
        {30'd0, in_ready, out_valid}, 32'd0);
    @(posedge clk); #1;
    step();
    flush = 1'b0;
    feed(5); idle(10);
    chk(beats_seen == 0, "R9", "flushed bytes gone", 32'(beats_seen), 32'd0);
    feed(3); idle(15);
    chk(beats_seen == 8, "R9", "fresh threshold", 32'(beats_seen), 32'd8);

    // R1: fill burst needs full free space before starting
    set_cfg(0, 2'd2, 2'd1, 2'd0, 2'd0, 2'd0);
    out_ready = 1'b0;
    feed(4);
    out_ready = 1'b1; idle(5);
    out_ready = 1'b0;
    @(negedge clk); #1;
    chk(in_ready == 1'b0, "R1", "burst needs 16 free", 32'(in_ready), 32'd0);
    @(posedge clk); #1;

    // random segments
    for (int s = 0; s < 20; s++) begin
      logic [1:0] ms, mbu, ps, pbu;
      do begin ms = 2'($urandom % 3); mbu = 2'($urandom % 4); end while (sz(ms) * bt(mbu) > 16);
      do begin ps = 2'($urandom % 3); pbu = 2'($urandom % 4); end while (sz(ps) * bt(pbu) > 16);
      set_cfg(($urandom % 5) == 0, ms, mbu, ps, pbu, 2'($urandom % 4));
      for (int c = 0; c < 250; c++) begin
        in_valid  = ($urandom % 10) < 7;
        in_data   = $urandom;
        out_ready = ($urandom % 10) < 7;
        step();
      end
    end
    in_valid = 1'b0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule